// File: doc/BRIEF.md
# Arbitration Loss Detector

This block monitors a wired-AND serial bus while several units contend for mastership. During the arbitration window, each time the bit sampler strobes, it compares the bit this unit is driving with the level seen on the line. The bus has a dominant level. If the unit drives the recessive level but reads back the dominant one, another unit has won. The detector then sets a sticky lost flag and raises a back-off signal, which tells the transmitter to stop driving for the rest of the window.

The lost flag stays set until the start of the next frame. Where it clears depends on who opened that frame. If this unit drives the start bit itself, the flag clears when the start-bit output begins. If this unit only observes a start bit from another unit, the flag clears when the receiver's start-bit detector fires. That detection comes noticeably later, for example about 160 µs into the start bit in the slow bus mode. The clear still happens at detection time when this unit wanted to be master but another unit started first.

Top module: `arb_loss_detector`

## Requirements
- R1: After a synchronous reset (`rst` high at a clock edge), `lost_flag` and `backoff` are 0.
- R2: With the default `DOMINANT_LVL` of 0, the bus level 1 is recessive. If a clock edge has `arb_win`=1, `sample_stb`=1, `tx_bit`=1 and `bus_bit`=0, and no clear event, `lost_flag` and `backoff` are 1 from the next cycle on.
- R3: A sampled bit where `tx_bit` equals `bus_bit`, or where `tx_bit`=0 and `bus_bit`=1, does not set `lost_flag` or `backoff`.
- R4: A recessive/dominant mismatch seen while `arb_win`=0 is ignored, and both outputs stay 0.
- R5: A recessive/dominant mismatch with `sample_stb`=0 is ignored.
- R6: Once set, `lost_flag` stays 1 through later bits and past the end of the arbitration window, until a clear event.
- R7: When `self_start`=1, a `start_out_stb` pulse clears `lost_flag` on the next cycle. A `start_det_stb` pulse has no effect.
- R8: When `self_start`=0, a `start_det_stb` pulse clears `lost_flag` on the next cycle. A `start_out_stb` pulse has no effect.
- R9: If a clear event and a mismatch fall on the same clock edge, the clear wins, and both outputs are 0 on the next cycle.
- R10: `backoff` is 1 only while `lost_flag` is 1. It drops on the cycle after an edge with `arb_win`=0, and it also drops on a clear event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_bit | input | 1 | Bit this unit is driving |
| bus_bit | input | 1 | Sampled bus level |
| sample_stb | input | 1 | One-cycle strobe marking a valid bus sample |
| arb_win | input | 1 | High during the arbitration period |
| self_start | input | 1 | This unit drives the start bit of the frame |
| start_out_stb | input | 1 | Pulse when this unit begins driving the start bit |
| start_det_stb | input | 1 | Pulse when the receiver detects a start bit |
| lost_flag | output | 1 | Sticky arbitration-lost flag |
| backoff | output | 1 | Tells the transmitter to stop driving |

## Verification
Both outputs are registered, so every result appears exactly one clock edge after the inputs that cause it. This covers a set, a clear, and the drop of back-off at the end of the window. The bench drives each input vector on a falling edge and lets one rising edge pass. It then compares both outputs, on the next falling edge, with a reference model that is updated from the same vector. Cases where set and clear coincide, and the strobes that must be ignored for each start-bit owner, each get their own vectors with the result checked in that following cycle.

// File: rtl/arbld_pkg.sv
package arbld_pkg;
  typedef struct packed {
    logic set;
    logic clr;
  } arb_evt_t;
endpackage

// File: rtl/arbld_compare.sv
module arbld_compare #(
  parameter bit DOMINANT_LVL = 1'b0
) (
  input  logic tx_bit,
  input  logic bus_bit,
  input  logic sample_stb,
  input  logic arb_win,
  output logic mismatch
);
  localparam bit RECESSIVE_LVL = ~DOMINANT_LVL;
  logic lost_bit;
  generate
    if (DOMINANT_LVL == 1'b0) begin : g_dom_low
      assign lost_bit = tx_bit & ~bus_bit;
    end else begin : g_dom_high
      assign lost_bit = ~tx_bit & bus_bit;
    end
  endgenerate
  // sanity on the derived recessive level: drove recessive, saw the other
  assign mismatch = sample_stb & arb_win & lost_bit & (tx_bit == RECESSIVE_LVL);
endmodule

// File: rtl/arbld_clear_sel.sv
module arbld_clear_sel (
  input  logic self_start,
  input  logic start_out_stb,
  input  logic start_det_stb,
  output logic clr
);
  // owner of the start bit picks which strobe ends the previous result
  always_comb begin
    if (self_start) clr = start_out_stb;
    else            clr = start_det_stb;
  end
endmodule

// File: rtl/arbld_state.sv
module arbld_state
  import arbld_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  arb_evt_t evt,
  input  logic     arb_win,
  output logic     lost_q,
  output logic     backoff_q
);
  always_ff @(posedge clk) begin
    if (rst || evt.clr) lost_q <= 1'b0;
    else if (evt.set)   lost_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || evt.clr || !arb_win) backoff_q <= 1'b0;
    else if (evt.set)               backoff_q <= 1'b1;
  end
endmodule

// File: rtl/arb_loss_detector.sv
module arb_loss_detector
  import arbld_pkg::*;
#(
  parameter bit DOMINANT_LVL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic tx_bit,
  input  logic bus_bit,
  input  logic sample_stb,
  input  logic arb_win,
  input  logic self_start,
  input  logic start_out_stb,
  input  logic start_det_stb,
  output logic lost_flag,
  output logic backoff
);
  arb_evt_t evt;
  logic     mism;
  logic     clr;

  arbld_compare #(.DOMINANT_LVL(DOMINANT_LVL)) u_cmp (
    .tx_bit(tx_bit), .bus_bit(bus_bit), .sample_stb(sample_stb),
    .arb_win(arb_win), .mismatch(mism)
  );

  arbld_clear_sel u_clr (
    .self_start(self_start), .start_out_stb(start_out_stb),
    .start_det_stb(start_det_stb), .clr(clr)
  );

  assign evt.set = mism;
  assign evt.clr = clr;

  arbld_state u_st (
    .clk(clk), .rst(rst), .evt(evt), .arb_win(arb_win),
    .lost_q(lost_flag), .backoff_q(backoff)
  );
endmodule

// File: rtl/arb_loss_detector_chk.sv
module arb_loss_detector_chk #(
  parameter bit DOMINANT_LVL = 1'b0
) (
  input logic clk,
  input logic rst,
  input logic tx_bit,
  input logic bus_bit,
  input logic sample_stb,
  input logic arb_win,
  input logic self_start,
  input logic start_out_stb,
  input logic start_det_stb,
  input logic lost_flag,
  input logic backoff
);
  logic any_clr;
  assign any_clr = self_start ? start_out_stb : start_det_stb;

  assert_set_on_loss_R2: assert property (@(posedge clk) disable iff (rst)
    (arb_win && sample_stb && tx_bit != DOMINANT_LVL && bus_bit == DOMINANT_LVL && !any_clr)
      |=> (lost_flag && backoff));

  assert_quiet_outside_R4: assert property (@(posedge clk) disable iff (rst)
    (!lost_flag && !(arb_win && sample_stb) && !$isunknown(lost_flag)) |=> !lost_flag);

  assert_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (lost_flag && !any_clr) |=> lost_flag);

  assert_clear_wins_R9: assert property (@(posedge clk) disable iff (rst)
    any_clr |=> (!lost_flag && !backoff));

  assert_backoff_window_R10: assert property (@(posedge clk) disable iff (rst)
    !arb_win |=> !backoff);

  assert_backoff_implies_flag_R10: assert property (@(posedge clk) disable iff (rst)
    backoff |-> lost_flag);
endmodule

bind arb_loss_detector arb_loss_detector_chk #(.DOMINANT_LVL(DOMINANT_LVL)) u_chk (.*);

// File: tb/tb_arb_loss_detector.sv
module tb_arb_loss_detector;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tx_bit = 1'b0, bus_bit = 1'b0, sample_stb = 1'b0, arb_win = 1'b0;
  logic self_start = 1'b0, start_out_stb = 1'b0, start_det_stb = 1'b0;
  logic lost_flag, backoff;

  int n_chk = 0;
  int n_fail = 0;
  bit exp_flag = 1'b0;
  bit exp_bo = 1'b0;

  always #5 clk = ~clk;

  arb_loss_detector dut (
    .clk(clk), .rst(rst), .tx_bit(tx_bit), .bus_bit(bus_bit),
    .sample_stb(sample_stb), .arb_win(arb_win), .self_start(self_start),
    .start_out_stb(start_out_stb), .start_det_stb(start_det_stb),
    .lost_flag(lost_flag), .backoff(backoff)
  );

  task automatic check(input string tag);
    n_chk++;
    if (lost_flag !== exp_flag) begin
      n_fail++;
      $display("FAIL %s lost_flag actual=%b expected=%b", tag, lost_flag, exp_flag);
    end
    n_chk++;
    if (backoff !== exp_bo) begin
      n_fail++;
      $display("FAIL %s backoff actual=%b expected=%b", tag, backoff, exp_bo);
    end
  endtask

  // Drive one vector on a falling edge, predict, let a rising edge pass, compare.
  task automatic step(input bit w, input bit s, input bit tx, input bit bus,
                      input bit own, input bit so, input bit sd, input string tag);
    bit lost_now, clear_now;
    arb_win = w; sample_stb = s; tx_bit = tx; bus_bit = bus;
    self_start = own; start_out_stb = so; start_det_stb = sd;
    lost_now  = w && s && tx && !bus;           // level 0 dominant
    clear_now = own ? so : sd;
    if (clear_now) begin exp_flag = 0; exp_bo = 0; end
    else begin
      if (lost_now) exp_flag = 1;
      if (!w) exp_bo = 0;
      else if (lost_now) exp_bo = 1;
    end
    @(posedge clk);
    @(negedge clk);
    check(tag);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 reset");
    // R3: equal bits and dominant-drive/recessive-read
    step(1,1,1,1,0,0,0,"R3 equal ones");
    step(1,1,0,0,0,0,0,"R3 equal zeros");
    step(1,1,0,1,0,0,0,"R3 drive dominant");
    // R4 outside window, R5 no strobe
    step(0,1,1,0,0,0,0,"R4 outside window");
    step(1,0,1,0,0,0,0,"R5 no strobe");
    // R2 loss
    step(1,1,1,0,0,0,0,"R2 loss sets");
    step(1,1,1,1,0,0,0,"R6 sticky matching bit");
    step(1,0,0,0,0,0,0,"R6 sticky idle");
    step(0,0,0,0,0,0,0,"R10 window end drops backoff");
    step(0,0,0,0,0,1,0,"R8 start_out ignored not owner");
    step(0,0,0,0,0,0,1,"R8 detect clears");
    // R7 owner
    step(1,1,1,0,1,0,0,"R2 loss as owner");
    step(1,0,0,0,1,0,1,"R7 detect ignored owner");
    step(1,0,0,0,1,1,0,"R7 start_out clears");
    // R9 clear with simultaneous mismatch
    step(1,1,1,0,0,0,0,"R2 set again");
    step(1,1,1,0,0,0,1,"R9 clear wins");
    step(1,1,1,0,1,1,0,"R9 clear wins owner");
    // R10 clear drops backoff mid window, then new loss
    step(1,1,1,0,0,0,0,"R10 set");
    step(1,1,1,1,0,0,1,"R10 clear drops backoff");
    step(1,1,1,0,0,0,0,"R10 reset then set");
    // R1 reset mid-state
    rst = 1'b1; exp_flag = 0; exp_bo = 0;
    @(posedge clk); @(negedge clk);
    check("R1 reset while set");
    rst = 1'b0;
    for (int i = 0; i < 40; i++) begin
      step(bit'((i % 7) != 0), bit'(i % 2), bit'((i / 2) % 2), bit'((i / 3) % 2),
           bit'((i / 5) % 2), bit'((i % 11) == 4), bit'((i % 13) == 6), "R6 mixed");
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule